// File: doc/BRIEF.md
# Static Memory Bus Cycle Sequencer

This block turns single requests from an internal port into timed bus cycles toward static memory. A three-bit field of the request address picks one of the memory areas the block serves. Each area has its own timing set and data bus width. For the selected area the block asserts a chip select and drives a read strobe, which can also serve as an output enable, or a set of per-byte write strobes. The timing of a cycle is made of four parts:
- an optional setup cycle before the strobe;
- a coded count of internal wait cycles;
- an extension for as long as an external active-low wait input is held low;
- zero to three hold cycles after the strobe.

A requester raises `req_valid` with its address, direction, size and write data, and holds them until it sees `req_ack`. It then drops `req_valid` on the next edge. A request is flagged with `req_err` and finishes without any bus activity in two cases: its address selects an area this block does not serve, or it is wider than that area's configured bus. Accesses are never split into narrower cycles.

Top module: `smem_cycle_seq`

## Requirements
- R1: Address bits 28..26 equal to 3'b010 select area 2, which drives `bus_cs_n[0]` low; 3'b011 selects area 3, which drives `bus_cs_n[1]` low. A chip select is low only during the setup, strobe and hold cycles of an access to its own area, and at most one is low at a time.
- R2: The 3-bit wait code of the selected area sets the internal wait count. Codes 0..7 give 0, 1, 2, 3, 4, 6, 8 and 15 waits, and the strobe lasts that count plus one cycle when the wait input stays high.
- R3: `bus_wait_n` is sampled on the last programmed strobe cycle and on every cycle after it. Each sample that is low adds one strobe cycle, and the strobe ends after the first sample that is high.
- R4: When the area's setup bit is 1, one cycle with the chip select low and the strobes high comes before the strobe. When the bit is 0 there is no such cycle.
- R5: The area's 2-bit hold field gives 0 to 3 cycles after the strobe, with the chip select low and the strobes high. The address stays stable for the whole time the chip select is low.
- R6: A read drives `bus_rd_n` low during the strobe and keeps every write strobe high. `req_rdata` returns the `bus_rdata` value present in the last strobe cycle.
- R7: A write drives the selected write strobes low during the strobe and keeps `bus_rd_n` high. `bus_wdata` carries the request data.
- R8: Size codes 0..3 mean 1, 2, 4 and 8 bytes. Width codes 0..3 mean 8-, 16-, 32- and 64-bit buses. The byte lane offset is the address's low three bits taken modulo the bus bytes, then aligned down to the access size. `bus_we_n[i]` is low exactly for the lanes from the offset to the offset plus the size minus one.
- R9: A request whose size code is greater than the area's width code is acknowledged with `req_err` high and asserts no chip select.
- R10: A request to any area other than 2 or 3 asserts no chip select. It is acknowledged with `req_err` high in the cycle right after it was accepted.
- R11: `req_ack` is a single-cycle pulse in the cycle after the last chip-select cycle, with every chip select high. `req_err` is high only together with `req_ack`, and low for a completed access.
- R12: After reset, all chip selects, `bus_rd_n` and all write strobes are high, and `req_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (1, 2, 4, 8 bytes) |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | Completion pulse |
| req_err | output | 1 | Error flag, valid with req_ack |
| req_rdata | output | DATA_W | Read data captured at end of strobe |
| cfg_setup | input | N_AREAS | Per-area setup enable |
| cfg_hold | input | 2*N_AREAS | Per-area hold cycles |
| cfg_wait | input | 3*N_AREAS | Per-area wait code |
| cfg_width | input | 2*N_AREAS | Per-area bus width code |
| bus_cs_n | output | N_AREAS | Active-low chip selects, bit 0 = area 2 |
| bus_rd_n | output | 1 | Active-low read strobe / output enable |
| bus_we_n | output | LANES | Active-low byte write strobes |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_wait_n | input | 1 | Active-low external wait |

## Verification
The assertions rely on the requester behaving correctly. It holds `req_valid` and the request fields stable until the acknowledge and drops `req_valid` right after it. It also leaves the configuration inputs unchanged while an access is in flight. The bench keeps to these rules: each scenario task programs the area timing only between accesses, raises a request on a falling edge, and clears `req_valid` on the same falling edge where it sees `req_ack`. The bench drives `bus_wait_n` low only for a fixed number of samples per access. The sequencer therefore always reaches its acknowledge, and the checks on the pulse and on the idle bus are tested on finished accesses.

// File: rtl/smem_pkg.sv
// Package: shared types and the wait-code table for the static memory
// sequencer. Assumes three-bit wait codes and two-bit hold/width fields.
package smem_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_STROBE,
        SEQ_HOLD,
        SEQ_ACK
    } seq_state_t;

    // Timing set for one area; field order is fixed by the top's packing.
    typedef struct packed {
        logic       setup;
        logic [1:0] hold;
        logic [2:0] wcode;
        logic [1:0] width;
    } area_timing_t;

    // Wait-code to internal wait cycle count.
    function automatic logic [3:0] wait_cycles(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd0;
            3'd1:    return 4'd1;
            3'd2:    return 4'd2;
            3'd3:    return 4'd3;
            3'd4:    return 4'd4;
            3'd5:    return 4'd6;
            3'd6:    return 4'd8;
            default: return 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/smem_area_decode.sv
// Area decoder: compares the area-select address field against each area
// this block serves and returns the hit flag, the area index and that
// area's timing set. Assumes areas are numbered consecutively from
// FIRST_AREA; the lowest matching index wins.
module smem_area_decode
    import smem_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int FIRST_AREA = 2,
    parameter int N_AREAS    = 2,
    localparam int IDX_W     = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic [SEL_W-1:0] sel_bits,
    input  area_timing_t     cfg [N_AREAS],
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output area_timing_t     sel
);

    logic [N_AREAS-1:0] match;

    // Per-area comparator.
    for (genvar g = 0; g < N_AREAS; g++) begin : g_match
        assign match[g] = (sel_bits == SEL_W'(FIRST_AREA + g));
    end

    // Pick the first matching area and its timing set.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        sel = cfg[0];
        for (int i = 0; i < N_AREAS; i++) begin
            if (match[i] && !hit) begin
                hit = 1'b1;
                idx = IDX_W'(i);
                sel = cfg[i];
            end
        end
    end

endmodule

// File: rtl/smem_lane_gen.sv
// Byte lane generator: turns the low address bits, the access size and the
// configured bus width into a byte-lane enable mask, and flags accesses
// wider than the bus. Assumes the bus width never exceeds LANES bytes.
module smem_lane_gen #(
    parameter int LANES = 8,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LW-1:0]    addr_lo,
    input  logic [1:0]       size,
    input  logic [1:0]       width,
    output logic [LANES-1:0] mask,
    output logic             too_wide
);

    logic [LW:0] nbytes;
    logic [LW:0] bus_bytes;
    logic [LW:0] offset;
    logic [LW:0] lane_end;

    // Lane offset: address modulo bus bytes, aligned down to access size.
    always_comb begin
        nbytes    = (LW + 1)'(1) << size;
        bus_bytes = (LW + 1)'(1) << width;
        offset    = {1'b0, addr_lo} & (bus_bytes - 1'b1) & ~(nbytes - 1'b1);
        lane_end  = offset + nbytes;
        too_wide  = (size > width);
    end

    // One enable per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = ((LW + 1)'(i) >= offset) && ((LW + 1)'(i) < lane_end);
    end

endmodule

// File: rtl/smem_seq_fsm.sv
// Cycle sequencer: steps through setup, strobe with internal and external
// waits, hold and acknowledge. A single counter is reused for the wait and
// hold phases. Assumes the start inputs are valid only in the cycle in
// which start is high.
module smem_seq_fsm
    import smem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_err,
    input  logic       setup,
    input  logic [1:0] hold,
    input  logic [3:0] wcount,
    input  logic       wait_n,
    output logic       cs_active,
    output logic       stb_active,
    output logic       capture,
    output logic       ack
);

    seq_state_t state;
    logic [3:0] cnt;
    logic [1:0] hold_q;

    // State and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            cnt    <= '0;
            hold_q <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        hold_q <= hold;
                        cnt    <= wcount;
                        if (start_err)  state <= SEQ_ACK;
                        else if (setup) state <= SEQ_SETUP;
                        else            state <= SEQ_STROBE;
                    end
                end
                SEQ_SETUP: state <= SEQ_STROBE;
                SEQ_STROBE: begin
                    if (cnt != 4'd0) begin
                        cnt <= cnt - 4'd1;
                    end else if (wait_n) begin
                        if (hold_q != 2'd0) begin
                            cnt   <= {2'b00, hold_q} - 4'd1;
                            state <= SEQ_HOLD;
                        end else begin
                            state <= SEQ_ACK;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (cnt == 4'd0) state <= SEQ_ACK;
                    else             cnt   <= cnt - 4'd1;
                end
                SEQ_ACK: state <= SEQ_IDLE;
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Phase decode for the bus pins.
    always_comb begin
        cs_active  = (state == SEQ_SETUP) || (state == SEQ_STROBE) || (state == SEQ_HOLD);
        stb_active = (state == SEQ_STROBE);
        capture    = stb_active && (cnt == 4'd0) && wait_n;
        ack        = (state == SEQ_ACK);
    end

endmodule

// File: rtl/smem_cycle_seq.sv
// Static memory bus cycle sequencer top: accepts one request at a time,
// decodes the area, latches the request and drives chip selects, read
// strobe and byte write strobes with per-area timing. Assumes the requester
// holds its request until req_ack and that configuration is static during
// an access.
module smem_cycle_seq
    import smem_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int N_AREAS    = 2,
    parameter int FIRST_AREA = 2,
    parameter int SEL_MSB    = 28,
    parameter int SEL_LSB    = 26,
    localparam int LANES     = DATA_W / 8,
    localparam int LW        = $clog2(LANES),
    localparam int SEL_W     = SEL_MSB - SEL_LSB + 1,
    localparam int IDX_W     = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ack,
    output logic                   req_err,
    output logic [DATA_W-1:0]      req_rdata,
    input  logic [N_AREAS-1:0]     cfg_setup,
    input  logic [2*N_AREAS-1:0]   cfg_hold,
    input  logic [3*N_AREAS-1:0]   cfg_wait,
    input  logic [2*N_AREAS-1:0]   cfg_width,
    output logic [N_AREAS-1:0]     bus_cs_n,
    output logic                   bus_rd_n,
    output logic [LANES-1:0]       bus_we_n,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W-1:0]      bus_rdata,
    input  logic                   bus_wait_n
);

    area_timing_t       cfg_arr [N_AREAS];
    area_timing_t       sel_cfg;
    logic               area_hit;
    logic [IDX_W-1:0]   area_idx;
    logic [LANES-1:0]   lane_mask;
    logic               too_wide;
    logic               idle_q;
    logic               start;
    logic               start_err;
    logic               cs_active;
    logic               stb_active;
    logic               capture;
    logic               ack;

    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [LANES-1:0]   mask_q;
    logic [IDX_W-1:0]   idx_q;
    logic               wr_q;
    logic               err_q;

    // Pack per-area configuration fields into timing sets.
    for (genvar g = 0; g < N_AREAS; g++) begin : g_cfg
        assign cfg_arr[g] = {cfg_setup[g], cfg_hold[2*g +: 2],
                             cfg_wait[3*g +: 3], cfg_width[2*g +: 2]};
    end

    smem_area_decode #(
        .SEL_W      (SEL_W),
        .FIRST_AREA (FIRST_AREA),
        .N_AREAS    (N_AREAS)
    ) decode_i (
        .sel_bits (req_addr[SEL_MSB:SEL_LSB]),
        .cfg      (cfg_arr),
        .hit      (area_hit),
        .idx      (area_idx),
        .sel      (sel_cfg)
    );

    smem_lane_gen #(
        .LANES (LANES)
    ) lanes_i (
        .addr_lo  (req_addr[LW-1:0]),
        .size     (req_size),
        .width    (sel_cfg.width),
        .mask     (lane_mask),
        .too_wide (too_wide)
    );

    // Accept a request only when the sequencer is idle.
    always_comb begin
        start     = idle_q && req_valid;
        start_err = !area_hit || too_wide;
    end

    smem_seq_fsm seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_err  (start_err),
        .setup      (sel_cfg.setup),
        .hold       (sel_cfg.hold),
        .wcount     (wait_cycles(sel_cfg.wcode)),
        .wait_n     (bus_wait_n),
        .cs_active  (cs_active),
        .stb_active (stb_active),
        .capture    (capture),
        .ack        (ack)
    );

    // Idle tracker: busy from accept until the acknowledge cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n)     idle_q <= 1'b1;
        else if (start) idle_q <= 1'b0;
        else if (ack)   idle_q <= 1'b1;
    end

    // Latch request fields at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= lane_mask;
            idx_q   <= area_idx;
            wr_q    <= req_write;
            err_q   <= start_err;
        end
    end

    // Capture read data at the end of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (capture && !wr_q) rdata_q <= bus_rdata;
    end

    // Chip select per area.
    for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
        assign bus_cs_n[g] = !(cs_active && (idx_q == IDX_W'(g)));
    end

    // Strobes and bus data.
    always_comb begin
        bus_rd_n  = !(stb_active && !wr_q);
        bus_we_n  = ~(mask_q & {LANES{stb_active && wr_q}});
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
        req_ack   = ack;
        req_err   = ack && err_q;
        req_rdata = rdata_q;
    end

endmodule

// File: rtl/smem_cycle_seq_chk.sv
// Checker for the sequencer's port protocol. Assumes a well-behaved
// requester; bound into every instance of the top.
module smem_cycle_seq_chk #(
    parameter int ADDR_W  = 32,
    parameter int N_AREAS = 2,
    parameter int LANES   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ack,
    input logic               req_err,
    input logic [N_AREAS-1:0] bus_cs_n,
    input logic               bus_rd_n,
    input logic [LANES-1:0]   bus_we_n,
    input logic [ADDR_W-1:0]  bus_addr
);

    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    assert_rd_we_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (&bus_we_n));

    assert_strobe_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !(&bus_we_n)) |-> !(&bus_cs_n));

    assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&bus_cs_n) && $past(!(&bus_cs_n))) |-> $stable(bus_addr));

    assert_err_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ack);

    assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_ack_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> ((&bus_cs_n) && bus_rd_n && (&bus_we_n)));

endmodule

bind smem_cycle_seq smem_cycle_seq_chk #(
    .ADDR_W  (ADDR_W),
    .N_AREAS (N_AREAS),
    .LANES   (LANES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ack  (req_ack),
    .req_err  (req_err),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_we_n (bus_we_n),
    .bus_addr (bus_addr)
);

// File: tb/smem_cycle_seq_tb_top.sv
// Directed bench for the static memory sequencer: one task per scenario.
module smem_cycle_seq_tb_top;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int NA     = 2;
    localparam int LANES  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ack;
    logic              req_err;
    logic [DATA_W-1:0] req_rdata;
    logic [NA-1:0]     cfg_setup = '0;
    logic [2*NA-1:0]   cfg_hold = '0;
    logic [3*NA-1:0]   cfg_wait = '0;
    logic [2*NA-1:0]   cfg_width = '0;
    logic [NA-1:0]     bus_cs_n;
    logic              bus_rd_n;
    logic [LANES-1:0]  bus_we_n;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              bus_wait_n = 1'b1;

    int errors = 0;
    int checks = 0;
    int t_setup [NA];
    int t_hold  [NA];
    int t_wcode [NA];
    int t_width [NA];

    always #2 clk = ~clk;

    smem_cycle_seq dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_size (req_size),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ack (req_ack), .req_err (req_err), .req_rdata (req_rdata),
        .cfg_setup (cfg_setup), .cfg_hold (cfg_hold),
        .cfg_wait (cfg_wait), .cfg_width (cfg_width),
        .bus_cs_n (bus_cs_n), .bus_rd_n (bus_rd_n), .bus_we_n (bus_we_n),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .bus_wait_n (bus_wait_n)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_waits(input int code);
        int tbl [8] = '{0, 1, 2, 3, 4, 6, 8, 15};
        return tbl[code];
    endfunction

    function automatic logic [7:0] exp_mask(input int size, input int width, input int lo);
        int nb  = 1 << size;
        int bb  = 1 << width;
        int off = lo % bb;
        logic [7:0] m = '0;
        off = off - (off % nb);
        for (int i = 0; i < 8; i++) m[i] = (i >= off) && (i < off + nb);
        return m;
    endfunction

    task automatic set_area(input int a, input int s, input int h, input int wc, input int wd);
        t_setup[a] = s; t_hold[a] = h; t_wcode[a] = wc; t_width[a] = wd;
        cfg_setup[a]       = 1'(s);
        cfg_hold[2*a +: 2] = 2'(h);
        cfg_wait[3*a +: 3] = 3'(wc);
        cfg_width[2*a +: 2] = 2'(wd);
    endtask

    // One access, observed cycle by cycle at falling edges.
    task automatic do_access(input int asel, input bit wr, input int size,
                             input int lo, input int ext, input string tag);
        bit handled = (asel == 2) || (asel == 3);
        int ai = handled ? asel - 2 : 0;
        bit exp_err;
        int w, n, pre, stb, post, cs, rd_low, wrong_cs;
        logic [7:0]  we_seen;
        logic [63:0] pat, wd_seen, rdata_seen;
        logic err_seen;
        bit got_ack;
        exp_err = !handled || (size > t_width[ai]);
        w = exp_waits(t_wcode[ai]);
        pat = {$urandom, $urandom};
        n = 0; pre = 0; stb = 0; post = 0; cs = 0; rd_low = 0; wrong_cs = 0;
        we_seen = '0; wd_seen = '0; rdata_seen = '0; err_seen = 1'b0; got_ack = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = 2'(size);
        req_addr  = {3'b000, 3'(asel), 23'h2A5A5A, 3'(lo)};
        req_wdata = ~pat;
        bus_wait_n = 1'b1;
        while (!got_ack && n < 100) begin
            @(negedge clk);
            n++;
            if (!bus_rd_n) rd_low++;
            if (!bus_rd_n || (bus_we_n != '1)) begin
                stb++;
                we_seen = ~bus_we_n;
                wd_seen = bus_wdata;
            end else if (bus_cs_n != '1) begin
                if (stb == 0) pre++;
                else          post++;
            end
            if (bus_cs_n != '1) begin
                cs++;
                if (!handled || (~bus_cs_n != (2'b01 << ai))) wrong_cs++;
            end
            bus_rdata  = !bus_rd_n ? pat : ~pat;
            bus_wait_n = (stb >= w + ext + 1);
            if (req_ack) begin
                got_ack = 1;
                err_seen = req_err;
                rdata_seen = req_rdata;
                req_valid = 1'b0;
            end
        end
        bus_wait_n = 1'b1;
        check({tag, " R11 ack seen"}, 64'(got_ack), 64'd1);
        @(negedge clk);
        check({tag, " R11 ack single pulse"}, 64'(req_ack), 64'd0);
        if (exp_err) begin
            check({tag, " R9/R10 error flag"}, 64'(err_seen), 64'd1);
            check({tag, " R10 ack in cycle after accept"}, 64'(n), 64'd1);
            check({tag, " R10 no chip select"}, 64'(cs), 64'd0);
        end else begin
            check({tag, " R11 no error"}, 64'(err_seen), 64'd0);
            check({tag, " R4 setup cycles"}, 64'(pre), 64'(t_setup[ai]));
            check({tag, " R2/R3 strobe cycles"}, 64'(stb), 64'(w + 1 + ext));
            check({tag, " R5 hold cycles"}, 64'(post), 64'(t_hold[ai]));
            check({tag, " R1 chip select cycles"}, 64'(cs), 64'(t_setup[ai] + w + 1 + ext + t_hold[ai]));
            check({tag, " R1 right chip select"}, 64'(wrong_cs), 64'd0);
            check({tag, " R11 ack timing"}, 64'(n), 64'(t_setup[ai] + w + 1 + ext + t_hold[ai] + 1));
            if (wr) begin
                check({tag, " R7 no read strobe"}, 64'(rd_low), 64'd0);
                check({tag, " R8 byte lanes"}, 64'(we_seen), 64'(exp_mask(size, t_width[ai], lo)));
                check({tag, " R7 write data"}, wd_seen, ~pat);
            end else begin
                check({tag, " R6 no write strobe"}, 64'(we_seen), 64'd0);
                check({tag, " R6 read data"}, rdata_seen, pat);
            end
        end
    endtask

    task automatic test_reset();
        check("R12 cs idle", 64'(bus_cs_n), 64'h3);
        check("R12 rd idle", 64'(bus_rd_n), 64'd1);
        check("R12 we idle", 64'(bus_we_n), 64'hFF);
        check("R12 ack low", 64'(req_ack), 64'd0);
    endtask

    task automatic test_wait_codes();
        for (int c = 0; c < 8; c++) begin
            set_area(0, 0, 0, c, 3);
            do_access(2, 1'b0, 3, 0, 0, $sformatf("R2 code%0d", c));
        end
    endtask

    task automatic test_setup_hold();
        for (int h = 0; h < 4; h++) begin
            set_area(1, 1, h, 1, 3);
            do_access(3, 1'b0, 2, 4, 0, $sformatf("R4/R5 hold%0d", h));
        end
        set_area(1, 0, 2, 0, 3);
        do_access(3, 1'b1, 0, 1, 0, "R4 no setup");
    endtask

    task automatic test_ext_wait();
        set_area(0, 1, 1, 2, 3);
        do_access(2, 1'b0, 1, 2, 3, "R3 ext3");
        set_area(1, 0, 0, 0, 2);
        do_access(3, 1'b1, 2, 0, 5, "R3 ext5");
    endtask

    task automatic test_lanes();
        set_area(0, 0, 0, 0, 3);
        do_access(2, 1'b1, 0, 5, 0, "R8 byte on 64");
        do_access(2, 1'b1, 3, 0, 0, "R8 dword on 64");
        set_area(0, 0, 1, 1, 2);
        do_access(2, 1'b1, 1, 6, 0, "R8 half on 32");
        set_area(1, 1, 0, 0, 1);
        do_access(3, 1'b1, 0, 3, 0, "R8 byte on 16");
        set_area(1, 0, 0, 0, 0);
        do_access(3, 1'b1, 0, 7, 0, "R8 byte on 8");
    endtask

    task automatic test_errors();
        set_area(0, 1, 3, 4, 1);
        do_access(2, 1'b1, 2, 0, 0, "R9 word on 16");
        do_access(2, 1'b0, 3, 0, 0, "R9 dword on 16");
        do_access(0, 1'b0, 0, 0, 0, "R10 area0");
        do_access(5, 1'b1, 0, 0, 0, "R10 area5");
        set_area(0, 0, 0, 0, 3);
        do_access(2, 1'b0, 3, 0, 0, "R11 after error");
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        set_area(0, 0, 0, 0, 3);
        set_area(1, 0, 0, 0, 3);
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_wait_codes();
        test_setup_hold();
        test_ext_wait();
        test_lanes();
        test_errors();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule